// File: doc/BRIEF.md
# Multi-core run/stop controller

This block lets software start and halt the processor cores of a cluster through three 64-bit registers on a simple synchronous bus. Writing a bit mask to the start register launches each selected core that is currently stopped. Writing a mask to the halt register stops each selected core that is currently active. A status register reports the per-core activity vector. Each start gives the core a one-cycle reset pulse, and each halt gives it a one-cycle halt request. The status bit changes on the same clock edge that produces the pulse.

The three registers appear in two identical windows: a local window at base 0x000 and a second window at base 0x100. Inside a window, the start register is at offset 0x10, the halt register at 0x18 and the status register at 0x20. The parameter `BOOT_MASK` selects the cores that start by themselves when reset ends. If `BOOT_MASK` names a core beyond `NUM_CORES`, elaboration is refused.

Top module: `core_runctl`

## Requirements
- R1: Only bits 0 to NUM_CORES-1 of the write data reach the core logic. Bits at or above NUM_CORES are ignored on writes to both the start register and the halt register.
- R2: A write to the start register (offset 0x10) raises `core_reset[i]` for exactly one cycle for each selected core i that is stopped. That pulse appears in the cycle after the write edge, and the core's status bit is set in the same cycle. Cores that are already running receive no pulse.
- R3: A write to the halt register (offset 0x18) raises `core_halt[i]` for one cycle and clears status bit i for each selected core i that is running. Cores that are already stopped receive no pulse.
- R4: A read of the status register (offset 0x20) returns the status vector in bits 0 to NUM_CORES-1 and zero above. `bus_rdata` shows the value for the address presented at a clock edge from the cycle after that edge.
- R5: Addresses 0x110, 0x118 and 0x120 behave exactly like 0x10, 0x18 and 0x20.
- R6: While `rst_n` is low, all status bits, pulses and read data are zero. At the first clock edge after reset is released, the cores in BOOT_MASK are started with the same pulse-and-set action as R2.
- R7: A read of any address other than a status register returns zero. This includes the start and halt offsets and addresses outside both windows. A write to such an address changes no state and produces no pulse.
- R8: A write of an all-zero mask to the start or halt register produces no pulse and no change in state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 64 | Write data (core mask) |
| bus_rdata | output | 64 | Registered read data |
| core_reset | output | NUM_CORES | One-cycle reset pulse per started core |
| core_halt | output | NUM_CORES | One-cycle halt request per stopped core |

## Verification
The assertions assume three things:
- The bus inputs carry known values on every clock edge once reset has been released.
- A write is a single-cycle strobe.
- `BOOT_MASK` lies within the core mask.

The stimulus drives every input to a defined value from time zero and changes it only on the falling clock edge. It holds `rst_n` low over several edges before each release and uses a legal boot mask of cores 0 and 2. The checks that link pulses to status changes rely on the fact that only one register is written per cycle.

// File: rtl/runctl_pkg.sv
package runctl_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RUN  = 2'd1,
    REG_STOP = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OFF_RUN  = 8'h10;
  localparam logic [7:0] OFF_STOP = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h20;

  // Mask of the low n bits, saturating at 64.
  function automatic logic [63:0] core_mask(input int unsigned n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Register select from the offset inside a window.
  function automatic reg_sel_e decode_offset(input logic [7:0] off);
    reg_sel_e s;
    case (off)
      OFF_RUN:  s = REG_RUN;
      OFF_STOP: s = REG_STOP;
      OFF_STAT: s = REG_STAT;
      default:  s = REG_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/runctl_decode.sv
module runctl_decode
  import runctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int WIN_W = ADDR_W - 8;

  logic [WIN_W-1:0] win;
  logic             win_hit;

  assign win     = addr[ADDR_W-1:8];
  assign win_hit = (win <= WIN_W'(1));
  assign sel     = win_hit ? decode_offset(addr[7:0]) : REG_NONE;
endmodule

// File: rtl/runctl_state.sv
module runctl_state #(
  parameter int          NUM_CORES = 4,
  parameter logic [63:0] BOOT_MASK = 64'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] run_req,
  input  logic [NUM_CORES-1:0] stop_req,
  output logic [NUM_CORES-1:0] running,
  output logic [NUM_CORES-1:0] start_pulse,
  output logic [NUM_CORES-1:0] halt_pulse
);
  localparam logic [NUM_CORES-1:0] BOOT_N = BOOT_MASK[NUM_CORES-1:0];

  logic                 boot_pend_q;
  logic [NUM_CORES-1:0] running_q;
  logic [NUM_CORES-1:0] start_q;
  logic [NUM_CORES-1:0] halt_q;
  logic [NUM_CORES-1:0] start_vec;
  logic [NUM_CORES-1:0] halt_vec;

  // Start only stopped cores; halt only running ones.
  assign start_vec = (run_req | (boot_pend_q ? BOOT_N : '0)) & ~running_q;
  assign halt_vec  = stop_req & running_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend_q <= 1'b1;
      running_q   <= '0;
      start_q     <= '0;
      halt_q      <= '0;
    end else begin
      boot_pend_q <= 1'b0;
      running_q   <= (running_q | start_vec) & ~halt_vec;
      start_q     <= start_vec;
      halt_q      <= halt_vec;
    end
  end

  assign running     = running_q;
  assign start_pulse = start_q;
  assign halt_pulse  = halt_q;
endmodule

// File: rtl/core_runctl.sv
module core_runctl
  import runctl_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter logic [63:0] BOOT_MASK = 64'h1,
  parameter int          ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic [NUM_CORES-1:0] core_reset,
  output logic [NUM_CORES-1:0] core_halt
);
  localparam logic [63:0] CORE_MASK = core_mask(NUM_CORES);

  if (NUM_CORES < 1 || NUM_CORES > 64) begin : g_bad_count
    $error("core_runctl: NUM_CORES must be in 1..64");
  end
  if ((BOOT_MASK & ~CORE_MASK) != 64'd0) begin : g_bad_boot
    $error("core_runctl: BOOT_MASK selects cores beyond NUM_CORES");
  end
  if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
    $error("core_runctl: ADDR_W must be in 9..16");
  end

  reg_sel_e             sel;
  logic [63:0]          wdata_masked;
  logic                 wr_run_hit;
  logic                 wr_stop_hit;
  logic                 rd_stat_hit;
  logic [NUM_CORES-1:0] run_req;
  logic [NUM_CORES-1:0] stop_req;
  logic [NUM_CORES-1:0] running_q;
  logic [63:0]          rdata_q;

  runctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wdata_masked = bus_wdata & CORE_MASK;
  assign wr_run_hit   = bus_wr && (sel == REG_RUN);
  assign wr_stop_hit  = bus_wr && (sel == REG_STOP);
  assign rd_stat_hit  = (sel == REG_STAT);
  assign run_req      = wr_run_hit  ? wdata_masked[NUM_CORES-1:0] : '0;
  assign stop_req     = wr_stop_hit ? wdata_masked[NUM_CORES-1:0] : '0;

  runctl_state #(.NUM_CORES(NUM_CORES), .BOOT_MASK(BOOT_MASK)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req     (run_req),
    .stop_req    (stop_req),
    .running     (running_q),
    .start_pulse (core_reset),
    .halt_pulse  (core_halt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_stat_hit ? 64'(running_q) : '0;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/runctl_chk.sv
module runctl_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] running,
  input logic [N-1:0] core_reset,
  input logic [N-1:0] core_halt,
  input logic [63:0]  bus_rdata,
  input logic         wr_run_hit,
  input logic         wr_stop_hit
);
  assert_start_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_reset & ~running) == '0) && ((core_reset & $past(running)) == '0));

  assert_halt_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_halt & running) == '0) && ((core_halt & ~$past(running)) == '0));

  assert_status_follows_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running == (($past(running) | core_reset) & ~core_halt));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(wr_run_hit) && !$past(wr_stop_hit))
      |-> (core_reset == '0 && core_halt == '0));

  assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> N) == 64'd0);
endmodule

bind core_runctl runctl_chk #(.N(NUM_CORES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .running     (running_q),
  .core_reset  (core_reset),
  .core_halt   (core_halt),
  .bus_rdata   (bus_rdata),
  .wr_run_hit  (wr_run_hit),
  .wr_stop_hit (wr_stop_hit)
);

// File: tb/sim_core_runctl.sv
module sim_core_runctl;
  localparam int          NC   = 4;
  localparam logic [63:0] BOOT = 64'h5;
  localparam int          AW   = 12;

  typedef struct {
    logic [NC-1:0] rst;
    logic [NC-1:0] hlt;
    logic [63:0]   rd;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic [NC-1:0] core_reset;
  logic [NC-1:0] core_halt;

  int checks = 0;
  int errors = 0;
  logic [NC-1:0] model_run = '0;
  exp_t q[$];
  bit done = 0;

  always #10 clk = ~clk;

  core_runctl #(.NUM_CORES(NC), .BOOT_MASK(BOOT), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_reset(core_reset), .core_halt(core_halt)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: mid-high phase, after the edge that produced the result.
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "core_reset", 64'(core_reset), 64'(e.rst));
      check(e.tag, "core_halt",  64'(core_halt),  64'(e.hlt));
      check(e.tag, "bus_rdata",  bus_rdata,       e.rd);
    end
  end

  // Driver: one access per cycle, the expectation comes from a bench model.
  task automatic op(input logic [AW-1:0] a, input logic w, input logic [63:0] d, input string tag);
    exp_t e;
    int win;
    int off;
    logic [NC-1:0] m;
    logic [NC-1:0] s;
    logic [NC-1:0] h;
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = w;
    bus_wdata = d;
    win = int'(a) / 256;
    off = int'(a) % 256;
    m = d[NC-1:0];
    s = '0;
    h = '0;
    e.rd = '0;
    if (win < 2 && off == 'h20) e.rd = 64'(model_run);
    if (w && win < 2 && off == 'h10) s = m & ~model_run;
    if (w && win < 2 && off == 'h18) h = m & model_run;
    model_run = (model_run | s) & ~h;
    e.rst = s;
    e.hlt = h;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
  endtask

  task automatic do_reset(input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(tag, "reset core_reset", 64'(core_reset), 64'd0);
    check(tag, "reset core_halt", 64'(core_halt), 64'd0);
    check(tag, "reset bus_rdata", bus_rdata, 64'd0);
    rst_n = 1'b1;
    model_run = BOOT[NC-1:0];
    e.rst = BOOT[NC-1:0];
    e.hlt = '0;
    e.rd  = '0;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    do_reset("R6 boot");
    op(12'h020, 1'b0, 64'd0, "R4 read status local");
    op(12'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFF2, "R1 R2 start masked");
    op(12'h120, 1'b0, 64'd0, "R5 read status alias");
    op(12'h010, 1'b1, 64'hF, "R2 start skips running");
    op(12'h118, 1'b1, 64'hF3, "R3 R5 R1 halt via alias");
    op(12'h018, 1'b1, 64'h3, "R3 halt skips stopped");
    op(12'h010, 1'b1, 64'h0, "R8 zero start");
    op(12'h018, 1'b1, 64'h0, "R8 zero halt");
    op(12'h018, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, "R1 halt upper bits only");
    op(12'h020, 1'b1, 64'hF, "R7 write status ignored");
    op(12'h030, 1'b1, 64'hF, "R7 write unknown offset");
    op(12'h210, 1'b1, 64'hF, "R7 write outside windows");
    op(12'h010, 1'b0, 64'd0, "R7 read start offset");
    op(12'h220, 1'b0, 64'd0, "R7 read outside windows");
    op(12'h020, 1'b0, 64'd0, "R4 status after ignored writes");
    op(12'h110, 1'b1, 64'h3, "R5 start via alias");
    op(12'h120, 1'b0, 64'd0, "R4 R5 status all");
    idle();
    do_reset("R6 reset clears and reboots");
    op(12'h020, 1'b0, 64'd0, "R6 status after reboot");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d expected items actual=%0d expected=0", q.size(), q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule